// File: doc/BRIEF.md
# DDR3 Power-Up Reset Sequencer

This block steps a DDR3 device through its power-up reset. It drives the memory reset pin and the clock-enable (CKE) pin from counters clocked by a reference clock of known frequency. A single-cycle start pulse launches the sequence. The block then holds the memory reset asserted for a minimum time, releases it, and keeps CKE low until a settle window has passed. It then raises CKE together with a done flag that the memory controller waits on before it issues mode-register or calibration commands.

The settle window is the longer of two waits. One is a fixed wait, given as a parameter in reference cycles. The other is a programmable delay: a 17-bit count whose unit is two or three reference cycles, chosen by an input. A polarity input sets whether the reset pin is asserted high or low, so that one netlist serves board variants that invert that pin. The controller must already be driving the memory clock before the sequence is launched, and the block refuses a start pulse until it is told so.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the block is idle with the memory reset asserted, CKE low and done low. A `rst` in the middle of a sequence abandons it.
- R2: A start pulse is taken only while `dram_clk_on` is high. With `dram_clk_on` low, a start pulse changes no output.
- R3: When a start pulse is taken at clock edge E0, the memory reset is asserted from E0 and released at edge E0+RST_HOLD_CYC.
- R4: CKE rises exactly max(CKE_WAIT_CYC, `cke_dly`*N) cycles after the edge that released reset. N is 2 when `cke_mult3` is 0 and 3 when it is 1. `cke_dly` is sampled on the release edge.
- R5: When `cke_dly`*N is not greater than CKE_WAIT_CYC, including `cke_dly` = 0, the fixed wait alone sets when CKE rises.
- R6: With `rst_pol` = 1 the reset pin is high while reset is asserted. With `rst_pol` = 0 the pin is low while reset is asserted (active low). A change of `rst_pol` reaches the pin one cycle later.
- R7: A start pulse that arrives during the reset hold or the CKE wait is ignored, and the sequence timing does not change.
- R8: Done rises on the same edge as CKE and stays high until a start pulse is taken. A taken start pulse clears done and CKE and reasserts reset on the next edge.
- R9: CKE is never high while the memory reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all timing is counted in its cycles |
| rst | input | 1 | Synchronous active-high block reset |
| start | input | 1 | Single-cycle pulse that launches the power-up sequence |
| dram_clk_on | input | 1 | High when the memory clock output is already running |
| rst_pol | input | 1 | Reset pin polarity: 1 = asserted high, 0 = asserted low |
| cke_mult3 | input | 1 | Unit of the programmable delay: 0 = 2 cycles, 1 = 3 cycles |
| cke_dly | input | DLY_W | Programmable CKE delay count |
| dram_rst_pin | output | 1 | Memory reset pin, registered |
| dram_cke | output | 1 | Memory clock-enable pin, registered |
| seq_done | output | 1 | Sequence complete, high together with CKE |

## Verification
On every cycle the assertions check four things. CKE and reset are never active together. Done always mirrors CKE and, once high, stays high until a start pulse arrives. Reset is released only after the hold timer has expired, and CKE rises only after both wait counters have expired. The pin level also matches the requested polarity, and the counters stay inside their ranges. Only the bench scenarios can show the exact cycle counts: the release edge, and the rising edge of CKE as the larger of the two waits for both delay units. They also show that start pulses are ignored inside the sequence or without a running memory clock, and that a block reset in the middle of a sequence abandons it.

// File: rtl/ddr3_pwrup_pkg.sv
package ddr3_pwrup_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // reset asserted, waiting for a start pulse
    ST_HOLD  = 2'd1,  // reset asserted, minimum hold running
    ST_WAIT  = 2'd2,  // reset released, CKE held low
    ST_READY = 2'd3   // CKE high, sequence complete
  } pwrup_state_e;

endpackage

// File: rtl/ddr3_pwrup_timer.sv
// Loadable down-counter that stops at zero and flags expiry.
module ddr3_pwrup_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  // A counter at zero stays there until it is reloaded (hold timing, R3)
  assert_timer_no_wrap_R3 : assert property (@(posedge clk) disable iff (rst)
    (expired && !load) |=> expired);

  // A non-zero counter goes down by exactly one per cycle when not loaded
  assert_timer_step_R3 : assert property (@(posedge clk) disable iff (rst)
    (!expired && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ddr3_pwrup_cke_dly.sv
// Programmable CKE delay: a count whose unit is MULT_LO or MULT_HI cycles.
// The prescaler starts at N-2 so that expiry lands exactly cnt*N cycles
// after the load edge, lined up with the fixed wait timer.
module ddr3_pwrup_cke_dly #(
  parameter int DLY_W   = 17,
  parameter int MULT_LO = 2,
  parameter int MULT_HI = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             mult_hi,
  output logic             expired
);

  localparam int PRE_W = (MULT_HI > 2) ? $clog2(MULT_HI) : 1;
  localparam logic [PRE_W-1:0] PRE_LO_RELOAD = PRE_W'(MULT_LO - 1);
  localparam logic [PRE_W-1:0] PRE_HI_RELOAD = PRE_W'(MULT_HI - 1);
  localparam logic [PRE_W-1:0] PRE_LO_FIRST  = PRE_W'(MULT_LO - 2);
  localparam logic [PRE_W-1:0] PRE_HI_FIRST  = PRE_W'(MULT_HI - 2);

  logic [DLY_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic             mult_hi_q;
  logic [PRE_W-1:0] pre_reload;

  assign pre_reload = mult_hi_q ? PRE_HI_RELOAD : PRE_LO_RELOAD;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      pre_q     <= '0;
      mult_hi_q <= 1'b0;
    end else if (load) begin
      cnt_q     <= load_val;
      mult_hi_q <= mult_hi;
      pre_q     <= mult_hi ? PRE_HI_FIRST : PRE_LO_FIRST;
    end else if (cnt_q != '0) begin
      if (pre_q == '0) begin
        cnt_q <= cnt_q - 1'b1;
        pre_q <= pre_reload;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end

  assign expired = (cnt_q == '0);

  // The prescaler never leaves the range of the selected unit (R4)
  assert_pre_range_R4 : assert property (@(posedge clk) disable iff (rst)
    pre_q <= pre_reload);

  // Once expired, the delay stays expired until reloaded (R4)
  assert_dly_no_wrap_R4 : assert property (@(posedge clk) disable iff (rst)
    (expired && !load) |=> expired);

endmodule

// File: rtl/ddr3_pwrup_seq.sv
// DDR3 power-up reset sequencer, top level.
module ddr3_pwrup_seq
  import ddr3_pwrup_pkg::*;
#(
  parameter int RST_HOLD_CYC = 40000,   // 200 us at 200 MHz
  parameter int CKE_WAIT_CYC = 100000,  // 500 us at 200 MHz
  parameter int DLY_W        = 17,
  parameter int MULT_LO      = 2,
  parameter int MULT_HI      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             dram_clk_on,
  input  logic             rst_pol,
  input  logic             cke_mult3,
  input  logic [DLY_W-1:0] cke_dly,
  output logic             dram_rst_pin,
  output logic             dram_cke,
  output logic             seq_done
);

  localparam int HOLD_W = $clog2(RST_HOLD_CYC + 1);
  localparam int WAIT_W = $clog2(CKE_WAIT_CYC + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(RST_HOLD_CYC - 1);
  localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(CKE_WAIT_CYC - 1);

  pwrup_state_e state_q, state_d;
  logic rst_act_q, rst_act_d;
  logic cke_d;
  logic go, release_now, cke_now;
  logic hold_exp, wait_exp, dly_exp;

  // Start is only honoured outside the timed phases and with the clock running
  assign go = start && dram_clk_on &&
              ((state_q == ST_IDLE) || (state_q == ST_READY));
  assign release_now = (state_q == ST_HOLD) && hold_exp;
  assign cke_now     = (state_q == ST_WAIT) && wait_exp && dly_exp;

  ddr3_pwrup_timer #(.CNT_W(HOLD_W)) u_hold_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (go),
    .load_val (HOLD_LOAD),
    .expired  (hold_exp)
  );

  ddr3_pwrup_timer #(.CNT_W(WAIT_W)) u_wait_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (release_now),
    .load_val (WAIT_LOAD),
    .expired  (wait_exp)
  );

  ddr3_pwrup_cke_dly #(
    .DLY_W   (DLY_W),
    .MULT_LO (MULT_LO),
    .MULT_HI (MULT_HI)
  ) u_cke_dly (
    .clk      (clk),
    .rst      (rst),
    .load     (release_now),
    .load_val (cke_dly),
    .mult_hi  (cke_mult3),
    .expired  (dly_exp)
  );

  always_comb begin
    state_d   = state_q;
    rst_act_d = rst_act_q;
    cke_d     = dram_cke;
    if (go) begin
      state_d   = ST_HOLD;
      rst_act_d = 1'b1;
      cke_d     = 1'b0;
    end else if (release_now) begin
      state_d   = ST_WAIT;
      rst_act_d = 1'b0;
    end else if (cke_now) begin
      state_d   = ST_READY;
      cke_d     = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      rst_act_q    <= 1'b1;
      dram_cke     <= 1'b0;
      seq_done     <= 1'b0;
      dram_rst_pin <= rst_pol;
    end else begin
      state_q      <= state_d;
      rst_act_q    <= rst_act_d;
      dram_cke     <= cke_d;
      seq_done     <= cke_d;
      dram_rst_pin <= rst_pol ? rst_act_d : !rst_act_d;
    end
  end

  // CKE is never driven high while the memory is held in reset
  assert_cke_vs_reset_R9 : assert property (@(posedge clk) disable iff (rst)
    dram_cke |-> !rst_act_q);

  // Done and CKE move together
  assert_done_with_cke_R8 : assert property (@(posedge clk) disable iff (rst)
    seq_done == dram_cke);

  // Done, once high, holds until a start pulse arrives
  assert_done_holds_R8 : assert property (@(posedge clk) disable iff (rst)
    (seq_done && !start) |=> seq_done);

  // Reset is released only after the hold timer has run out
  assert_release_after_hold_R3 : assert property (@(posedge clk) disable iff (rst)
    $fell(rst_act_q) |-> $past(hold_exp));

  // CKE rises only once both the fixed wait and the programmed delay are over
  assert_cke_after_waits_R4 : assert property (@(posedge clk) disable iff (rst)
    $rose(dram_cke) |-> $past(wait_exp && dly_exp));

  // Pin level encodes the reset state in the requested polarity
  assert_pin_polarity_R6 : assert property (@(posedge clk) disable iff (rst)
    dram_rst_pin == ($past(rst_pol) ? rst_act_q : !rst_act_q));

  // A start without a running memory clock is refused
  assert_no_start_without_clk_R2 : assert property (@(posedge clk) disable iff (rst)
    (start && !dram_clk_on && state_q == ST_READY) |=> dram_cke);

endmodule

// File: tb/test_ddr3_pwrup_seq.sv
`timescale 1ns/1ps
module test_ddr3_pwrup_seq;

  localparam int H     = 10;
  localparam int W     = 20;
  localparam int DLY_W = 17;
  localparam int NVEC  = 8;

  // Vector fields: {rst_pol, cke_mult3, inject cycle (0 = none), cke_dly}
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'd0,  17'd0 },  // dly 0: fixed wait 20
    {1'b1, 1'b0, 8'd0,  17'd5 },  // 10 < 20
    {1'b0, 1'b0, 8'd0,  17'd10},  // 20 = 20
    {1'b0, 1'b0, 8'd0,  17'd11},  // 22 > 20
    {1'b1, 1'b1, 8'd0,  17'd7 },  // 21
    {1'b0, 1'b1, 8'd5,  17'd30},  // 90, start during hold
    {1'b1, 1'b0, 8'd25, 17'd15},  // 30, start during wait
    {1'b0, 1'b1, 8'd0,  17'd1 }   // 3 < 20
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic dram_clk_on = 1'b1;
  logic rst_pol = 1'b0;
  logic cke_mult3 = 1'b0;
  logic [DLY_W-1:0] cke_dly = '0;
  logic dram_rst_pin, dram_cke, seq_done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ddr3_pwrup_seq #(
    .RST_HOLD_CYC (H),
    .CKE_WAIT_CYC (W),
    .DLY_W        (DLY_W)
  ) i_ddr3_pwrup_seq (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .dram_clk_on  (dram_clk_on),
    .rst_pol      (rst_pol),
    .cke_mult3    (cke_mult3),
    .cke_dly      (cke_dly),
    .dram_rst_pin (dram_rst_pin),
    .dram_cke     (dram_cke),
    .seq_done     (seq_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic pin_for(input logic pol, input logic asserted);
    return pol ? asserted : !asserted;
  endfunction

  // Run one sequence; k counts edges since the start edge E0, sampled on negedges
  task automatic run_seq(input logic pol, input logic m3, input int inj,
                         input logic [DLY_W-1:0] dly);
    int n, x;
    n = m3 ? 3 : 2;
    x = (int'(dly) * n > W) ? int'(dly) * n : W;
    rst_pol   = pol;
    cke_mult3 = m3;
    cke_dly   = dly;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);          // E0 has passed
    start = 1'b0;
    for (int k = 0; k <= H + x + 1; k++) begin
      chk("R3 R6 reset pin", dram_rst_pin, pin_for(pol, k < H));
      chk(inj != 0 ? "R4 R5 R7 cke" : "R4 R5 cke", dram_cke, (k >= H + x));
      chk("R8 done", seq_done, (k >= H + x));
      chk("R9 cke vs reset", dram_cke && (k < H), 1'b0);
      start = (inj != 0 && k == inj);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 pin in reset", dram_rst_pin, 1'b0);
    chk("R1 cke in reset", dram_cke, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pin after reset", dram_rst_pin, 1'b0);
    chk("R1 cke after reset", dram_cke, 1'b0);
    chk("R1 done after reset", seq_done, 1'b0);

    // R6: polarity change in idle reaches the pin one cycle later
    rst_pol = 1'b1;
    @(negedge clk);
    chk("R6 pol high idle", dram_rst_pin, 1'b1);
    rst_pol = 1'b0;
    @(negedge clk);
    chk("R6 pol low idle", dram_rst_pin, 1'b0);

    // R2: start without running clock is refused in idle
    dram_clk_on = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (H + W + 3) @(negedge clk);
    chk("R2 cke stays low", dram_cke, 1'b0);
    chk("R2 pin stays asserted", dram_rst_pin, 1'b0);
    dram_clk_on = 1'b1;

    // Vector table: R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      run_seq(VEC[i][26], VEC[i][25], int'(VEC[i][24:17]), VEC[i][16:0]);
    end

    // R8: done holds while no start arrives
    repeat (30) @(negedge clk);
    chk("R8 done holds", seq_done, 1'b1);
    chk("R8 cke holds", dram_cke, 1'b1);

    // R2: start in READY with clock off changes nothing
    dram_clk_on = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 done kept", seq_done, 1'b1);
    chk("R2 cke kept", dram_cke, 1'b1);
    chk("R2 pin kept released", dram_rst_pin, 1'b1);
    dram_clk_on = 1'b1;

    // R1: block reset in the middle of the CKE wait abandons the sequence
    rst_pol = 1'b1;
    cke_dly = '0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (H + 5) @(negedge clk);
    chk("R1 released before abort", dram_rst_pin, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 abort pin asserted", dram_rst_pin, 1'b1);
    chk("R1 abort cke low", dram_cke, 1'b0);
    chk("R1 abort done low", seq_done, 1'b0);
    rst = 1'b0;
    repeat (W + 5) @(negedge clk);
    chk("R1 stays idle after abort", dram_cke, 1'b0);

    // Sequence after the abort still runs normally
    run_seq(1'b0, 1'b0, 0, 17'd12);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule